// File: doc/BRIEF.md
# Matrix Accumulator Hazard Interlock

This block sits at the issue stage of a vector core that runs matrix multiply-accumulate (MMA) operations out of a separate accumulator register file. Each cycle the candidate instruction comes in with its class, its MMA shape, its destination range and up to three source ranges. A range is a base index plus a length. The interlock compares the candidate with a shift history of the slots issued in recent cycles. It then reports how many idle slots must still pass before the candidate is safe to issue.

The candidate is presented with `in_valid` and issues in a cycle where `in_ready` is high. The interlock holds `in_ready` low while the stall count on `stall_cnt` is nonzero. Every cycle without an issue enters the history as an empty slot, so a waiting candidate sees its count fall by one per cycle. The required spacing depends on several things: the latency class of the producing MMA, which source slot of a consumer MMA reads the register (A/B or the accumulate input C), and whether the ranges only partly overlap. A chain that accumulates into an identical range needs no gap.

Top module: `mma_hazard_interlock`

## Requirements
- R1: Class codes on `in_cls` are 0 other, 1 vector ALU, 2 vector ALU that writes the execution mask, 3 MMA, 4 move-into-accumulator, 5 move-out-of-accumulator. An MMA or move-into-accumulator issued after a class-2 instruction needs 4 wait states.
- R2: An MMA or move-into-accumulator needs 2 wait states after an instruction that wrote one of its vector sources. The writers that count are classes 1, 2 and 5, and their destination is in the vector file. An MMA source A or B is a vector source when its `_acc` bit is 0. The source of a move-into-accumulator is always `a`, in the vector file.
- R3: An MMA destination that overlaps a later MMA's accumulator A or B source needs 4 wait states. One that overlaps the later MMA's C source needs 2.
- R4: If the producing MMA's destination range is identical in base and length to the consumer's range, that pair raises no hazard. Same-range accumulation chains issue back to back.
- R5: Shape codes on `in_shape` are 0 for latency 2, 1 for latency 8, 2 for latency 16 and 3 for any other latency. A move-out-of-accumulator whose source (`a`) overlaps an earlier MMA destination needs 4, 10, 18 or 18 wait states for shapes 0 to 3.
- R6: A move-into-accumulator whose destination overlaps an earlier MMA destination needs 1, 7, 15 or 15 wait states for shapes 0 to 3.
- R7: After a move-into-accumulator, an overlapping read needs the following wait states:
  - 1 for an MMA C source;
  - 3 for an accumulator MMA A/B source;
  - 3 for a move-out-of-accumulator source;
  - 3 for a later move-into-accumulator destination.
- R8: A move-into-accumulator whose destination overlaps the C source of an earlier MMA needs 0, 5, 13 or 13 wait states for shapes 0 to 3.
- R9: For each history slot, the slot's required spacing is reduced by k, where k is the number of slots issued or left idle since that producer. With `acc_used` high the window covers the last 18 slots. With it low the window covers only the last 5.
- R10: `stall_cnt` is the maximum over all rules and all history slots, floored at zero.
- R11: `stall_cnt` is 0 while `in_valid` is low. `in_ready` is high exactly when `stall_cnt` is 0. A held, unchanged candidate sees `stall_cnt` drop by one each cycle until it issues.
- R12: Candidates of class 0, 1 or 2 never stall. An operand of length 0 is absent and overlaps nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset; empties the history |
| acc_used | input | 1 | 1: 18-slot window, 0: 5-slot window |
| in_valid | input | 1 | Candidate present |
| in_cls | input | 3 | Candidate class code (R1) |
| in_shape | input | 2 | MMA latency code (R5) |
| in_dst_base | input | 8 | Destination range base |
| in_dst_len | input | 5 | Destination range length, 0 = none |
| in_a_base | input | 8 | Source A base |
| in_a_len | input | 5 | Source A length |
| in_a_acc | input | 1 | Source A lives in the accumulator file |
| in_b_base | input | 8 | Source B base |
| in_b_len | input | 5 | Source B length |
| in_b_acc | input | 1 | Source B lives in the accumulator file |
| in_c_base | input | 8 | Source C (accumulator) base |
| in_c_len | input | 5 | Source C length |
| in_ready | output | 1 | Candidate may issue this cycle |
| stall_cnt | output | 5 | Idle slots still required |

## Verification
The mask-write rule and the vector-data rule can both be pending against one consumer in the same cycle. To provoke this, the bench issues a mask-writing ALU op and then an ALU op that writes a register, and follows them with an MMA that reads that register. That MMA faces 4-1 = 3 from the mask rule and 2 from the data rule. It is judged correct only if it reports 3 and waits exactly three cycles. Each shape latency is also driven against each accumulator consumer kind, including elapsed idle gaps and the narrow window.

// File: rtl/mhi_pkg.sv
`timescale 1ns/1ps
// Package: shared widths, instruction classes, operand and history types,
// and the small helper functions used by the spacing rules.
package mhi_pkg;
    localparam int REG_W  = 8;   // register index width
    localparam int LEN_W  = 5;   // range length width (up to 31)
    localparam int WAIT_W = 5;   // wait-state count width (max 18)

    typedef enum logic [2:0] {
        CL_OTHER   = 3'd0,
        CL_VALU    = 3'd1,
        CL_VMASK   = 3'd2,
        CL_MMA     = 3'd3,
        CL_ACC_IN  = 3'd4,
        CL_ACC_OUT = 3'd5
    } cls_e;

    typedef struct packed {
        logic [REG_W-1:0] base;
        logic [LEN_W-1:0] len;
    } span_t;

    // What a history slot remembers about an issued instruction.
    typedef struct packed {
        cls_e       cls;
        logic [1:0] shape;
        span_t      dst;
        span_t      srcc;
    } hist_t;

    // What a rule needs to know about the candidate.
    typedef struct packed {
        cls_e  cls;
        span_t dst;
        span_t srca;
        logic  a_acc;
        span_t srcb;
        logic  b_acc;
        span_t srcc;
    } cand_t;

    // Interval intersection; a zero-length range meets nothing.
    function automatic logic spans_meet(span_t x, span_t y);
        logic [REG_W:0] x_end, y_end;
        x_end = {1'b0, x.base} + {{(REG_W+1-LEN_W){1'b0}}, x.len};
        y_end = {1'b0, y.base} + {{(REG_W+1-LEN_W){1'b0}}, y.len};
        return (x.len != '0) && (y.len != '0) &&
               ({1'b0, x.base} < y_end) && ({1'b0, y.base} < x_end);
    endfunction

    // Overlap that is not an identical range (accumulation chains are exempt).
    function automatic logic spans_clash(span_t x, span_t y);
        return spans_meet(x, y) && (x != y);
    endfunction

    // Pick a spacing by producer latency class; code 3 takes the slowest.
    function automatic logic [WAIT_W-1:0] by_shape(logic [1:0] s, int w2, int w8, int w16);
        case (s)
            2'd0:    return WAIT_W'(w2);
            2'd1:    return WAIT_W'(w8);
            default: return WAIT_W'(w16);
        endcase
    endfunction

    function automatic logic [WAIT_W-1:0] wmax(logic [WAIT_W-1:0] a, logic [WAIT_W-1:0] b);
        return (a > b) ? a : b;
    endfunction
endpackage

// File: rtl/mhi_history.sv
`timescale 1ns/1ps
// mhi_history: shift register of the last DEPTH issue slots.
// Slot 0 holds the slot issued in the previous cycle. An idle cycle pushes
// an empty (class OTHER) entry. Assumes DEPTH >= 2.
module mhi_history
    import mhi_pkg::*;
#(
    parameter int DEPTH = 18
) (
    input  logic              clk,
    input  logic              rst_n,
    input  hist_t             push,
    output hist_t [DEPTH-1:0] slots
);
    // Age every slot by one and insert this cycle's entry at the young end.
    always_ff @(posedge clk) begin
        if (!rst_n) slots <= '0;
        else        slots <= {slots[DEPTH-2:0], push};
    end
endmodule

// File: rtl/mhi_pair_rule.sv
`timescale 1ns/1ps
// mhi_pair_rule: spacing still owed between one history slot of fixed age
// AGE (slots elapsed since that producer) and the current candidate.
// Assumes AGE fits in WAIT_W bits.
module mhi_pair_rule
    import mhi_pkg::*;
#(
    parameter int AGE = 0
) (
    input  hist_t             prod,
    input  cand_t             cand,
    output logic [WAIT_W-1:0] need
);
    localparam logic [WAIT_W-1:0] AGE_W = WAIT_W'(AGE);

    logic [WAIT_W-1:0] req;
    logic              vec_writer;
    logic              acc_feeder;

    // Full spacing this producer demands of the candidate, before ageing.
    always_comb begin
        req        = '0;
        vec_writer = (prod.cls == CL_VALU) || (prod.cls == CL_VMASK) || (prod.cls == CL_ACC_OUT);
        acc_feeder = (cand.cls == CL_MMA) || (cand.cls == CL_ACC_IN);
        // mask written by vector ALU
        if (acc_feeder && prod.cls == CL_VMASK)
            req = wmax(req, 5'd4);
        // vector data written then read by MMA or move-in
        if (acc_feeder && vec_writer) begin
            if (!cand.a_acc && spans_meet(prod.dst, cand.srca))
                req = wmax(req, 5'd2);
            if (cand.cls == CL_MMA && !cand.b_acc && spans_meet(prod.dst, cand.srcb))
                req = wmax(req, 5'd2);
        end
        // producer is an MMA
        if (prod.cls == CL_MMA) begin
            if (cand.cls == CL_MMA) begin
                if (cand.a_acc && spans_clash(prod.dst, cand.srca)) req = wmax(req, 5'd4);
                if (cand.b_acc && spans_clash(prod.dst, cand.srcb)) req = wmax(req, 5'd4);
                if (spans_clash(prod.dst, cand.srcc))               req = wmax(req, 5'd2);
            end else if (cand.cls == CL_ACC_OUT) begin
                if (spans_clash(prod.dst, cand.srca))
                    req = wmax(req, by_shape(prod.shape, 4, 10, 18));
            end else if (cand.cls == CL_ACC_IN) begin
                if (spans_clash(prod.dst, cand.dst))
                    req = wmax(req, by_shape(prod.shape, 1, 7, 15));
                if (spans_meet(prod.srcc, cand.dst))
                    req = wmax(req, by_shape(prod.shape, 0, 5, 13));
            end
        end
        // producer is a move-into-accumulator
        if (prod.cls == CL_ACC_IN) begin
            if (cand.cls == CL_MMA) begin
                if (cand.a_acc && spans_meet(prod.dst, cand.srca)) req = wmax(req, 5'd3);
                if (cand.b_acc && spans_meet(prod.dst, cand.srcb)) req = wmax(req, 5'd3);
                if (spans_meet(prod.dst, cand.srcc))               req = wmax(req, 5'd1);
            end else if (cand.cls == CL_ACC_OUT) begin
                if (spans_meet(prod.dst, cand.srca)) req = wmax(req, 5'd3);
            end else if (cand.cls == CL_ACC_IN) begin
                if (spans_meet(prod.dst, cand.dst))  req = wmax(req, 5'd3);
            end
        end
    end

    // Subtract the slots already elapsed, floored at zero.
    always_comb begin
        need = (int'(req) > AGE) ? (req - AGE_W) : '0;
    end
endmodule

// File: rtl/mma_hazard_interlock.sv
`timescale 1ns/1ps
// mma_hazard_interlock: issue-stage interlock for MMA / accumulator traffic.
// It compares the candidate against the last HIST_DEPTH issue slots and
// reports the idle slots still needed. It assumes the consumer of in_ready
// issues the candidate in any cycle where in_valid and in_ready are both
// high. Each rule reports zero once its window has elapsed.
module mma_hazard_interlock
    import mhi_pkg::*;
#(
    parameter int HIST_DEPTH   = 18,
    parameter int NARROW_DEPTH = 5
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              acc_used,
    input  logic              in_valid,
    input  logic [2:0]        in_cls,
    input  logic [1:0]        in_shape,
    input  logic [REG_W-1:0]  in_dst_base,
    input  logic [LEN_W-1:0]  in_dst_len,
    input  logic [REG_W-1:0]  in_a_base,
    input  logic [LEN_W-1:0]  in_a_len,
    input  logic              in_a_acc,
    input  logic [REG_W-1:0]  in_b_base,
    input  logic [LEN_W-1:0]  in_b_len,
    input  logic              in_b_acc,
    input  logic [REG_W-1:0]  in_c_base,
    input  logic [LEN_W-1:0]  in_c_len,
    output logic              in_ready,
    output logic [WAIT_W-1:0] stall_cnt
);
    cand_t                  cand;
    hist_t                  push;
    hist_t [HIST_DEPTH-1:0] slots;
    logic [WAIT_W-1:0]      need [HIST_DEPTH];
    logic [WAIT_W-1:0]      need_win [HIST_DEPTH];
    logic [WAIT_W-1:0]      worst;
    logic                   issue;

    // Gather the candidate fields into the rule-facing record.
    always_comb begin
        cand.cls   = cls_e'(in_cls);
        cand.dst   = '{base: in_dst_base, len: in_dst_len};
        cand.srca  = '{base: in_a_base,   len: in_a_len};
        cand.a_acc = in_a_acc;
        cand.srcb  = '{base: in_b_base,   len: in_b_len};
        cand.b_acc = in_b_acc;
        cand.srcc  = '{base: in_c_base,   len: in_c_len};
    end

    // History entry for this cycle: the issued candidate, or an empty slot.
    always_comb begin
        issue      = in_valid && in_ready;
        push       = '0;
        if (issue) begin
            push.cls   = cand.cls;
            push.shape = in_shape;
            push.dst   = cand.dst;
            push.srcc  = cand.srcc;
        end
    end

    mhi_history #(.DEPTH(HIST_DEPTH)) i_history (
        .clk   (clk),
        .rst_n (rst_n),
        .push  (push),
        .slots (slots)
    );

    // One rule evaluator per history age; the older ones drop out in the narrow window.
    for (genvar g = 0; g < HIST_DEPTH; g++) begin : g_age
        mhi_pair_rule #(.AGE(g)) i_rule (
            .prod (slots[g]),
            .cand (cand),
            .need (need[g])
        );
        if (g < NARROW_DEPTH) begin : g_near
            assign need_win[g] = need[g];
        end else begin : g_far
            assign need_win[g] = acc_used ? need[g] : '0;
        end
    end

    // Largest outstanding spacing over every history slot.
    always_comb begin
        worst = '0;
        for (int i = 0; i < HIST_DEPTH; i++)
            if (need_win[i] > worst) worst = need_win[i];
    end

    // Handshake outputs.
    always_comb begin
        stall_cnt = in_valid ? worst : '0;
        in_ready  = (stall_cnt == '0);
    end
endmodule

// File: rtl/mhi_checker.sv
`timescale 1ns/1ps
// mhi_checker: port-level properties of the interlock, bound to every instance.
module mhi_checker (
    input logic       clk,
    input logic       rst_n,
    input logic       acc_used,
    input logic       in_valid,
    input logic [2:0] in_cls,
    input logic [1:0] in_shape,
    input logic [7:0] in_dst_base,
    input logic [4:0] in_dst_len,
    input logic [7:0] in_a_base,
    input logic [4:0] in_a_len,
    input logic       in_a_acc,
    input logic [7:0] in_b_base,
    input logic [4:0] in_b_len,
    input logic       in_b_acc,
    input logic [7:0] in_c_base,
    input logic [4:0] in_c_len,
    input logic       in_ready,
    input logic [4:0] stall_cnt
);
    logic [57:0] cand_bits;
    assign cand_bits = {in_cls, in_shape, in_dst_base, in_dst_len, in_a_base, in_a_len, in_a_acc,
                        in_b_base, in_b_len, in_b_acc, in_c_base, in_c_len};

    AST_STALL_STEP: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && !in_ready) |=> ((in_valid && $stable(cand_bits) && $stable(acc_used))
                                     |-> (stall_cnt == $past(stall_cnt) - 5'd1))); // R11

    AST_FREE_CLASS: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && (in_cls <= 3'd2 || in_cls >= 3'd6)) |-> (stall_cnt == 5'd0)); // R12

    AST_STALL_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
        stall_cnt <= 5'd18); // R5

    AST_MASK_GAP: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && in_ready && in_cls == 3'd2)
        |=> ((in_valid && (in_cls == 3'd3 || in_cls == 3'd4)) |-> (stall_cnt >= 5'd4))); // R1
endmodule

bind mma_hazard_interlock mhi_checker i_mhi_checker (
    .clk(clk), .rst_n(rst_n), .acc_used(acc_used), .in_valid(in_valid),
    .in_cls(in_cls), .in_shape(in_shape),
    .in_dst_base(in_dst_base), .in_dst_len(in_dst_len),
    .in_a_base(in_a_base), .in_a_len(in_a_len), .in_a_acc(in_a_acc),
    .in_b_base(in_b_base), .in_b_len(in_b_len), .in_b_acc(in_b_acc),
    .in_c_base(in_c_base), .in_c_len(in_c_len),
    .in_ready(in_ready), .stall_cnt(stall_cnt)
);

// File: tb/test_mma_hazard_interlock.sv
`timescale 1ns/1ps
// Directed bench: each scenario task flushes history, issues producers and
// probes a consumer, checking the stall count and the cycles actually waited.
module test_mma_hazard_interlock;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       acc_used = 1'b1;
    logic       in_valid = 1'b0;
    logic [2:0] in_cls = '0;
    logic [1:0] in_shape = '0;
    logic [7:0] in_dst_base = '0, in_a_base = '0, in_b_base = '0, in_c_base = '0;
    logic [4:0] in_dst_len = '0, in_a_len = '0, in_b_len = '0, in_c_len = '0;
    logic       in_a_acc = 1'b0, in_b_acc = 1'b0;
    logic       in_ready;
    logic [4:0] stall_cnt;
    int         n_run = 0;
    int         n_bad = 0;

    always #10 clk = ~clk;   // 50 MHz

    mma_hazard_interlock i_mma_hazard_interlock (
        .clk(clk), .rst_n(rst_n), .acc_used(acc_used), .in_valid(in_valid),
        .in_cls(in_cls), .in_shape(in_shape),
        .in_dst_base(in_dst_base), .in_dst_len(in_dst_len),
        .in_a_base(in_a_base), .in_a_len(in_a_len), .in_a_acc(in_a_acc),
        .in_b_base(in_b_base), .in_b_len(in_b_len), .in_b_acc(in_b_acc),
        .in_c_base(in_c_base), .in_c_len(in_c_len),
        .in_ready(in_ready), .stall_cnt(stall_cnt)
    );

    task automatic chk(input string req, input int act, input int exp);
        n_run++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s: got %0d expected %0d", req, act, exp);
        end
    endtask

    // At the next falling edge, load a candidate (valid left as is).
    task automatic drive(input int cls, input int shp, input int d, input int dl,
                         input int a, input int al, input int aa,
                         input int b, input int bl, input int ba,
                         input int c, input int cl);
        @(negedge clk);
        in_cls = 3'(cls); in_shape = 2'(shp);
        in_dst_base = 8'(d); in_dst_len = 5'(dl);
        in_a_base = 8'(a); in_a_len = 5'(al); in_a_acc = 1'(aa);
        in_b_base = 8'(b); in_b_len = 5'(bl); in_b_acc = 1'(ba);
        in_c_base = 8'(c); in_c_len = 5'(cl);
    endtask

    task automatic gap(input int g);
        for (int i = 0; i < g; i++) begin
            @(negedge clk);
            in_valid = 1'b0;
        end
    endtask

    task automatic flush();
        gap(20);
    endtask

    // Issue the loaded candidate as a producer; it must be free to go.
    task automatic issue_now(input string req);
        in_valid = 1'b1;
        #2;
        if (!in_ready) begin
            n_run++; n_bad++;
            $display("FAIL %s: producer blocked, stall %0d expected 0", req, stall_cnt);
            while (!in_ready) begin @(negedge clk); #2; end
        end
        @(posedge clk);
    endtask

    // Present the loaded candidate; check the first count and the cycles waited.
    task automatic probe(input int exp, input string req);
        int waited;
        in_valid = 1'b1;
        #2;
        chk(req, int'(stall_cnt), exp);
        waited = 0;
        while (!in_ready) begin
            @(negedge clk); #2;
            waited++;
        end
        chk({req, " cycles"}, waited, exp);
        @(posedge clk);
    endtask

    // Short forms: producers and consumers used by the scenarios.
    task automatic valu(input int cls, input int d);
        drive(cls, 0, d, 1, 0, 0, 0, 0, 0, 0, 0, 0);
    endtask
    task automatic mma(input int shp, input int d, input int dl, input int a, input int aa,
                       input int b, input int ba, input int c, input int cl);
        drive(3, shp, d, dl, a, 1, aa, b, 1, ba, c, cl);
    endtask
    task automatic acc_in(input int d, input int src);
        drive(4, 0, d, 1, src, 1, 0, 0, 0, 0, 0, 0);
    endtask
    task automatic acc_out(input int src, input int sl, input int d);
        drive(5, 0, d, 1, src, sl, 1, 0, 0, 0, 0, 0);
    endtask

    task automatic t_reset();
        mma(0, 4, 4, 1, 0, 2, 0, 0, 4);
        in_valid = 1'b1;
        #2;
        chk("R11 reset stall", int'(stall_cnt), 0);
        chk("R11 reset ready", int'(in_ready), 1);
        in_valid = 1'b0;
        #2;
        chk("R11 idle stall", int'(stall_cnt), 0);
    endtask

    task automatic t_mask();
        flush(); valu(2, 10); issue_now("R1");
        mma(0, 4, 4, 1, 0, 2, 0, 0, 4); probe(4, "R1 mask->mma");
        flush(); valu(2, 10); issue_now("R1");
        gap(1); acc_in(0, 3); probe(3, "R1 mask->move-in gap1");
    endtask

    task automatic t_vec();
        flush(); valu(1, 5); issue_now("R2");
        mma(0, 4, 4, 1, 0, 5, 0, 0, 4); probe(2, "R2 valu->mma srcB");
        flush(); acc_out(4, 1, 0); issue_now("R2");
        acc_in(0, 0); probe(2, "R2 move-out->move-in");
        flush(); valu(1, 5); issue_now("R2");
        mma(0, 4, 4, 6, 0, 7, 0, 0, 4); probe(0, "R2 unrelated reg");
    endtask

    task automatic t_partial();
        flush(); mma(0, 0, 4, 1, 0, 2, 0, 0, 4); issue_now("R3");
        mma(0, 8, 4, 1, 1, 2, 0, 8, 4); probe(4, "R3 partial srcA");
        flush(); mma(0, 1, 4, 1, 0, 2, 0, 0, 4); issue_now("R3");
        mma(0, 0, 4, 1, 0, 2, 0, 0, 4); probe(2, "R3 partial srcC");
    endtask

    task automatic t_chain();
        flush(); mma(0, 0, 4, 1, 0, 2, 0, 0, 4); issue_now("R4");
        mma(0, 0, 4, 1, 0, 2, 0, 0, 4); probe(0, "R4 same range 4x4");
        flush(); mma(2, 0, 16, 1, 0, 2, 0, 0, 16); issue_now("R4");
        mma(2, 0, 16, 1, 0, 2, 0, 0, 16); probe(0, "R4 same range 32x32");
    endtask

    task automatic t_out();
        int exp_out [4] = '{4, 10, 18, 18};
        for (int s = 0; s < 4; s++) begin
            flush(); mma(s, 0, 16, 1, 0, 2, 0, 16, 16); issue_now("R5");
            acc_out(0, 1, 9); probe(exp_out[s], $sformatf("R5 move-out shape %0d", s));
        end
        flush(); mma(1, 0, 16, 1, 0, 2, 0, 16, 16); issue_now("R9");
        gap(3); acc_out(0, 1, 9); probe(7, "R9 elapsed gap3");
    endtask

    task automatic t_in();
        int exp_in [4] = '{1, 7, 15, 15};
        for (int s = 0; s < 4; s++) begin
            flush(); mma(s, 0, 16, 1, 0, 2, 0, 16, 16); issue_now("R6");
            acc_in(0, 9); probe(exp_in[s], $sformatf("R6 move-in over dst shape %0d", s));
        end
    endtask

    task automatic t_after_in();
        flush(); acc_in(8, 1); issue_now("R7");
        mma(0, 8, 4, 1, 0, 2, 0, 8, 4); probe(1, "R7 move-in->srcC");
        flush(); acc_in(8, 1); issue_now("R7");
        mma(0, 20, 4, 8, 1, 2, 0, 20, 4); probe(3, "R7 move-in->srcA");
        flush(); acc_in(8, 1); issue_now("R7");
        acc_out(8, 1, 9); probe(3, "R7 move-in->move-out");
        flush(); acc_in(8, 1); issue_now("R7");
        acc_in(8, 2); probe(3, "R7 move-in->move-in");
    endtask

    task automatic t_srcc();
        int exp_c [3] = '{0, 5, 13};
        for (int s = 0; s < 3; s++) begin
            flush(); mma(s, 16, 16, 1, 0, 2, 0, 0, 16); issue_now("R8");
            acc_in(0, 9); probe(exp_c[s], $sformatf("R8 move-in over srcC shape %0d", s));
        end
    endtask

    task automatic t_window();
        flush(); acc_used = 1'b0;
        mma(2, 0, 16, 1, 0, 2, 0, 16, 16); issue_now("R9");
        gap(5); acc_out(0, 1, 9); probe(0, "R9 narrow window");
        flush(); acc_used = 1'b1;
        mma(2, 0, 16, 1, 0, 2, 0, 16, 16); issue_now("R9");
        gap(5); acc_out(0, 1, 9); probe(13, "R9 wide window");
    endtask

    task automatic t_max();
        flush(); valu(2, 10); issue_now("R10");
        valu(1, 3); issue_now("R10");
        mma(0, 4, 4, 3, 0, 7, 0, 0, 4); probe(3, "R10 max of mask and data");
    endtask

    task automatic t_free();
        flush(); mma(2, 0, 16, 1, 0, 2, 0, 16, 16); issue_now("R12");
        drive(1, 0, 30, 1, 0, 16, 1, 0, 0, 0, 0, 0); probe(0, "R12 valu never waits");
        flush(); mma(2, 0, 16, 1, 0, 2, 0, 16, 16); issue_now("R12");
        drive(0, 0, 0, 16, 0, 0, 0, 0, 0, 0, 0, 0); probe(0, "R12 other never waits");
        flush(); mma(2, 0, 16, 1, 0, 2, 0, 16, 16); issue_now("R12");
        acc_out(0, 0, 9); probe(0, "R12 zero-length source");
    endtask

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk); rst_n = 1'b1;
        t_reset();
        t_mask();
        t_vec();
        t_partial();
        t_chain();
        t_out();
        t_in();
        t_after_in();
        t_srcc();
        t_window();
        t_max();
        t_free();
        $display("[TB] %0d tests run, %0d failed", n_run, n_bad);
        $finish;
    end

    initial begin
        #3_000_000;
        n_run++; n_bad++;
        $display("FAIL watchdog: got timeout expected completion");
        $display("[TB] %0d tests run, %0d failed", n_run, n_bad);
        $finish;
    end
endmodule